// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits beside the pad logic of a 32-bit multiplexed address/data bus with a 4-bit command/byte-enable field. It watches the framing and ready strobes, tracks whether the bus is idle or inside a transaction, and knows from two role inputs whether this agent started the transaction or was selected as its target. Whenever this agent puts address or data on the bus, the block drives the matching even parity bit one clock later. Whenever this agent is the one receiving data, it checks the parity that arrives one clock after each completed transfer against its own computation.

A mismatch sets a sticky status bit at once. If error reporting is enabled, the block then pulls the active-low error line low two clocks after the transfer that carried the bad data. After the last low cycle it holds the line high for two clocks and then lets it float. The output enables for the parity pin and the error pin are separate ports, so the pad ring builds the tri-state buffers itself.

The transaction tracker has two states. BUS_IDLE moves to BUS_DATA on an address phase, which is a low frame strobe seen while idle. BUS_DATA moves back to BUS_IDLE when frame is high and either a transfer completes or the initiator-ready is high. The error line controller has three states. PE_OFF moves to PE_LOW on a report. PE_LOW stays while reports continue and otherwise moves to PE_HIGH. PE_HIGH counts two cycles and then moves to PE_OFF, unless a new report sends it back to PE_LOW.

Top module: `bus_parity_unit`

## Requirements
- R1: Whenever `par_oe_o` is high, `par_o` equals the XOR of the 32 `ad_i` bits and the 4 `cbe_n_i` bits sampled at the previous rising edge. The 37 bits together therefore have even parity.
- R2: An address phase is a clock where `frame_n_i` is low while the bus is idle. The command is taken from `cbe_n_i` in that clock: bit 0 set means write, and 4'b0001 means special cycle. `par_oe_o` is high in the cycle after an address phase only if `master_i` was high in that phase.
- R3: In a write that this agent initiated, `par_oe_o` is high in the cycle after each data clock with `irdy_n_i` low. It is low after a data clock with `irdy_n_i` high.
- R4: In a read where `tgt_sel_i` is high, `par_oe_o` is high in the cycle after each data clock with `trdy_n_i` low. It is low after a clock with `trdy_n_i` high, and low after every data clock of a read that this agent initiated.
- R5: The receiving agent is the selected target on a write, or the initiator on a read. For a transfer that the receiving agent sees at edge k, a mismatch in `par_i` at edge k+1 makes `perr_n_o` low with `perr_oe_o` high in the cycle after edge k+2. A matching `par_i`, or a transfer this agent sent, never lowers `perr_n_o`.
- R6: After its last low cycle, the error line is driven high with `perr_oe_o` high for exactly two cycles, and then `perr_oe_o` goes low. A new error during those two cycles drives the line low again.
- R7: Transfers in a special-cycle transaction are never checked. Bad parity on them leaves `par_err_o` and `perr_oe_o` low.
- R8: Only clocks with both `irdy_n_i` and `trdy_n_i` low are checked. Bad parity following a wait-state clock is ignored.
- R9: `par_err_o` goes high in the cycle after edge k+1 on any mismatch and stays high until reset. When `perr_en_i` is low at edge k+1, the error line is not driven.
- R10: While `rst_n` is low, `par_oe_o`, `perr_oe_o` and `par_err_o` are low and `perr_n_o` is high. The bus tracker returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data pins as seen on the bus |
| cbe_n_i | input | 4 | Command / byte-enable pins |
| par_i | input | 1 | Parity pin as seen on the bus |
| frame_n_i | input | 1 | Frame strobe, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| master_i | input | 1 | This agent owns the current transaction (sampled at the address phase) |
| tgt_sel_i | input | 1 | This agent is the selected target (live during data phases) |
| perr_en_i | input | 1 | Enables driving the parity error line |
| par_o | output | 1 | Generated parity value |
| par_oe_o | output | 1 | Output enable for the parity pin |
| perr_n_o | output | 1 | Parity error line value, active low |
| perr_oe_o | output | 1 | Output enable for the parity error line |
| par_err_o | output | 1 | Sticky parity error detected status |

## Verification
The generator is tried with four patterns: initiator reads, initiator writes with wait states from each side, target reads with target wait states, and non-selected address phases. These separate the three driving conditions from each other and from the idle case, and they show that parity follows the data clock by exactly one cycle. The checker is tried with target writes and initiator reads carrying one bad word, two bad words back to back, bad parity after a wait-state clock, bad parity in a special cycle, and bad parity with reporting disabled. Together these tell apart the receiving role, the two-clock delay, the drive-high release sequence and its restart, the qualification by both ready strobes, the special-cycle exclusion, and the sticky status that is independent of the enable.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE,
        BUS_DATA
    } bus_st_t;

    typedef enum logic [1:0] {
        PE_OFF,
        PE_LOW,
        PE_HIGH
    } perr_st_t;

    typedef struct packed {
        logic master;
        logic write;
        logic special;
    } xact_t;

endpackage

// File: rtl/bpu_bus_track.sv
module bpu_bus_track
    import bpu_pkg::*;
#(
    parameter int CBE_W       = 4,
    parameter int WRITE_BIT   = 0,
    parameter logic [CBE_W-1:0] SPECIAL_CMD = 4'b0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic             trdy_n_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    input  logic             master_i,
    output logic             addr_phase_o,
    output logic             data_cycle_o,
    output logic             xfer_o,
    output xact_t            xact_o
);

    bus_st_t state_q, state_d;
    xact_t   xact_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            xact_q  <= '0;
        end else begin
            state_q <= state_d;
            if (addr_phase_o) begin
                xact_q.master  <= master_i;
                xact_q.write   <= cbe_n_i[WRITE_BIT];
                xact_q.special <= (cbe_n_i == SPECIAL_CMD);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (!frame_n_i) state_d = BUS_DATA;
            BUS_DATA: if (frame_n_i && (irdy_n_i || !trdy_n_i)) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        addr_phase_o = (state_q == BUS_IDLE) && !frame_n_i;
        data_cycle_o = (state_q == BUS_DATA);
        xfer_o       = data_cycle_o && !irdy_n_i && !trdy_n_i;
        xact_o       = xact_q;
    end

endmodule

// File: rtl/bpu_par_pipe.sv
module bpu_par_pipe #(
    parameter int DATA_W = 32,
    parameter int CBE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [CBE_W-1:0]  cbe_n_i,
    input  logic              par_i,
    input  logic              drive_i,
    input  logic              check_i,
    input  logic              perr_en_i,
    output logic              par_o,
    output logic              par_oe_o,
    output logic              report_o,
    output logic              sticky_o
);

    localparam int TOT_W = DATA_W + CBE_W;

    logic [TOT_W-1:0] bits;
    logic             local_par;
    logic             par_q, oe_q, chk_q, rep_q, sticky_q;
    logic             mismatch;

    assign bits = {ad_i, cbe_n_i};

    // XOR fold, written as a generated chain so width follows the parameters
    logic [TOT_W-1:0] fold;
    assign fold[0] = bits[0];
    for (genvar i = 1; i < TOT_W; i++) begin : g_fold
        assign fold[i] = fold[i-1] ^ bits[i];
    end
    assign local_par = fold[TOT_W-1];

    assign mismatch = chk_q && (par_i != par_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q    <= 1'b0;
            oe_q     <= 1'b0;
            chk_q    <= 1'b0;
            rep_q    <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            par_q    <= local_par;
            oe_q     <= drive_i;
            chk_q    <= check_i;
            rep_q    <= mismatch && perr_en_i;
            sticky_q <= sticky_q || mismatch;
        end
    end

    assign par_o    = par_q;
    assign par_oe_o = oe_q;
    assign report_o = rep_q;
    assign sticky_o = sticky_q;

endmodule

// File: rtl/bpu_perr_ctl.sv
module bpu_perr_ctl
    import bpu_pkg::*;
#(
    parameter int HOLD_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic report_i,
    output logic perr_n_o,
    output logic perr_oe_o
);

    localparam int CNT_W = (HOLD_HI < 2) ? 1 : $clog2(HOLD_HI);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_HI - 1);

    perr_st_t         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PE_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PE_OFF: begin
                if (report_i) state_d = PE_LOW;
            end
            PE_LOW: begin
                if (!report_i) begin
                    state_d = PE_HIGH;
                    cnt_d   = '0;
                end
            end
            PE_HIGH: begin
                if (report_i) begin
                    state_d = PE_LOW;
                end else if (cnt_q == LAST) begin
                    state_d = PE_OFF;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PE_OFF;
        endcase
    end

    // outputs
    always_comb begin
        perr_oe_o = (state_q != PE_OFF);
        perr_n_o  = (state_q != PE_LOW);
    end

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CBE_W   = 4,
    parameter int HOLD_HI = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [CBE_W-1:0]  cbe_n_i,
    input  logic              par_i,
    input  logic              frame_n_i,
    input  logic              irdy_n_i,
    input  logic              trdy_n_i,
    input  logic              master_i,
    input  logic              tgt_sel_i,
    input  logic              perr_en_i,
    output logic              par_o,
    output logic              par_oe_o,
    output logic              perr_n_o,
    output logic              perr_oe_o,
    output logic              par_err_o
);

    logic  addr_phase, data_cycle, xfer, drive, check, report;
    xact_t xact;

    bpu_bus_track #(
        .CBE_W       (CBE_W),
        .WRITE_BIT   (0),
        .SPECIAL_CMD (CBE_W'(1))
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n_i    (frame_n_i),
        .irdy_n_i     (irdy_n_i),
        .trdy_n_i     (trdy_n_i),
        .cbe_n_i      (cbe_n_i),
        .master_i     (master_i),
        .addr_phase_o (addr_phase),
        .data_cycle_o (data_cycle),
        .xfer_o       (xfer),
        .xact_o       (xact)
    );

    // who owns the AD pins this clock
    always_comb begin
        drive = (addr_phase && master_i)
             || (data_cycle && xact.write && xact.master && !irdy_n_i)
             || (data_cycle && !xact.write && tgt_sel_i && !trdy_n_i);
        check = xfer && !xact.special
             && (xact.write ? tgt_sel_i : xact.master);
    end

    bpu_par_pipe #(
        .DATA_W (DATA_W),
        .CBE_W  (CBE_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ad_i      (ad_i),
        .cbe_n_i   (cbe_n_i),
        .par_i     (par_i),
        .drive_i   (drive),
        .check_i   (check),
        .perr_en_i (perr_en_i),
        .par_o     (par_o),
        .par_oe_o  (par_oe_o),
        .report_o  (report),
        .sticky_o  (par_err_o)
    );

    bpu_perr_ctl #(
        .HOLD_HI (HOLD_HI)
    ) u_perr (
        .clk       (clk),
        .rst_n     (rst_n),
        .report_i  (report),
        .perr_n_o  (perr_n_o),
        .perr_oe_o (perr_oe_o)
    );

endmodule

// File: rtl/bus_parity_unit_chk.sv
module bus_parity_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CBE_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ad_i,
    input logic [CBE_W-1:0]  cbe_n_i,
    input logic              perr_en_i,
    input logic              par_o,
    input logic              par_oe_o,
    input logic              perr_n_o,
    input logic              perr_oe_o,
    input logic              par_err_o
);

    assert_even_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> (par_o == $past(^{ad_i, cbe_n_i})));

    assert_low_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> perr_oe_o);

    assert_low_after_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_n_o) |-> $past(par_err_o));

    assert_release_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_oe_o) |-> ($past(perr_n_o, 1) && $past(perr_n_o, 2) && $past(perr_oe_o, 2)));

    assert_gate_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_n_o) |-> $past(perr_en_i, 2));

    assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |=> par_err_o);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!perr_oe_o && !par_oe_o && !par_err_o);
        end
    end

endmodule

bind bus_parity_unit bus_parity_unit_chk #(
    .DATA_W (DATA_W),
    .CBE_W  (CBE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ad_i      (ad_i),
    .cbe_n_i   (cbe_n_i),
    .perr_en_i (perr_en_i),
    .par_o     (par_o),
    .par_oe_o  (par_oe_o),
    .perr_n_o  (perr_n_o),
    .perr_oe_o (perr_oe_o),
    .par_err_o (par_err_o)
);

// File: tb/sim_bus_parity_unit.sv
`timescale 1ns/1ps
module sim_bus_parity_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        par = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        master = 1'b0, tgt = 1'b0, perr_en = 1'b1;
    logic        par_o, par_oe, perr_n, perr_oe, par_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bus_parity_unit u0 (
        .clk (clk), .rst_n (rst_n), .ad_i (ad), .cbe_n_i (cbe), .par_i (par),
        .frame_n_i (frame_n), .irdy_n_i (irdy_n), .trdy_n_i (trdy_n),
        .master_i (master), .tgt_sel_i (tgt), .perr_en_i (perr_en),
        .par_o (par_o), .par_oe_o (par_oe), .perr_n_o (perr_n),
        .perr_oe_o (perr_oe), .par_err_o (par_err)
    );

    function automatic logic ep(input logic [31:0] d, input logic [3:0] c);
        return ^{d, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_bus();
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; tgt = 1'b0;
    endtask

    task automatic addr(input logic [31:0] a, input logic [3:0] cmd, input logic m);
        frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
        ad = a; cbe = cmd; master = m;
    endtask

    task automatic data(input logic fr, input logic ir, input logic tr,
                        input logic [31:0] d, input logic [3:0] be);
        frame_n = fr; irdy_n = ir; trdy_n = tr; ad = d; cbe = be;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle_bus(); master = 1'b0; perr_en = 1'b1; par = 1'b0;
        #1;
        chk("R10 par_oe", par_oe, 0);
        chk("R10 perr_oe", perr_oe, 0);
        chk("R10 perr_n", perr_n, 1);
        chk("R10 par_err", par_err, 0);
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // target receives a write with one bad word
    task automatic t_write_target_err();
        do_reset();
        addr(32'h1000_0040, 4'b0111, 1'b0); step();
        chk("R2 no drive when not master", par_oe, 0);
        tgt = 1'b1; data(1'b1, 1'b0, 1'b0, 32'hA5A5_0001, 4'b0000); step();
        chk("R4 receiver does not drive", par_oe, 0);
        idle_bus(); par = ~ep(32'hA5A5_0001, 4'b0000); step();
        chk("R9 sticky at k+1", par_err, 1);
        chk("R5 line idle at k+1", perr_oe, 0);
        step();
        chk("R5 perr_n low", perr_n, 0);
        chk("R5 perr_oe high", perr_oe, 1);
        step();
        chk("R6 high 1 n", perr_n, 1);
        chk("R6 high 1 oe", perr_oe, 1);
        step();
        chk("R6 high 2 n", perr_n, 1);
        chk("R6 high 2 oe", perr_oe, 1);
        step();
        chk("R6 released", perr_oe, 0);
        rst_n = 1'b0; #1;
        chk("R10 sticky cleared", par_err, 0);
    endtask

    // initiator read: address parity, clean data, then bad data
    task automatic t_read_master();
        do_reset();
        addr(32'h0000_7FF3, 4'b0110, 1'b1); step();
        chk("R2 addr drive", par_oe, 1);
        chk("R1 addr parity", par_o, ep(32'h0000_7FF3, 4'b0110));
        data(1'b1, 1'b0, 1'b0, 32'h1234_5678, 4'b0000); step();
        chk("R4 initiator read no drive", par_oe, 0);
        idle_bus(); par = ep(32'h1234_5678, 4'b0000); step();
        chk("R5 good parity no status", par_err, 0);
        step(); step();
        chk("R5 good parity line idle", perr_oe, 0);
        addr(32'h0000_8000, 4'b0110, 1'b1); step();
        data(1'b1, 1'b0, 1'b0, 32'hFFFF_0000, 4'b0000); step();
        idle_bus(); par = ~ep(32'hFFFF_0000, 4'b0000); step();
        chk("R9 initiator status", par_err, 1);
        step();
        chk("R5 initiator read error low", perr_n, 0);
    endtask

    // initiator write with wait states from both sides
    task automatic t_write_master();
        do_reset();
        addr(32'h2000_0000, 4'b0111, 1'b1); step();
        chk("R2 write addr drive", par_oe, 1);
        data(1'b0, 1'b1, 1'b1, 32'hDEAD_0000, 4'b0011); step();
        chk("R3 no drive while irdy high", par_oe, 0);
        tgt = 1'b0; data(1'b1, 1'b0, 1'b1, 32'h0F0F_F0F1, 4'b0011); step();
        chk("R3 drive after irdy", par_oe, 1);
        chk("R1 write parity", par_o, ep(32'h0F0F_F0F1, 4'b0011));
        data(1'b1, 1'b0, 1'b0, 32'h0F0F_F0F1, 4'b0011); par = 1'b0; step();
        chk("R3 drive on transfer", par_oe, 1);
        idle_bus(); par = ~ep(32'h0F0F_F0F1, 4'b0011); step();
        chk("R3 stop after end", par_oe, 0);
        chk("R5 sender never checks", par_err, 0);
    endtask

    // target read with a target wait state
    task automatic t_read_target();
        do_reset();
        addr(32'h3000_0004, 4'b0110, 1'b0); step();
        tgt = 1'b1; data(1'b1, 1'b0, 1'b1, 32'h5555_AAAA, 4'b0000); step();
        chk("R4 no drive during trdy wait", par_oe, 0);
        data(1'b1, 1'b0, 1'b0, 32'h8000_0001, 4'b1110); step();
        chk("R4 target drive", par_oe, 1);
        chk("R1 target parity", par_o, ep(32'h8000_0001, 4'b1110));
        idle_bus(); step();
        chk("R4 stop after end", par_oe, 0);
    endtask

    // bad parity after a wait-state clock is ignored
    task automatic t_wait_ignored();
        do_reset();
        addr(32'h4000_0000, 4'b0111, 1'b0); step();
        tgt = 1'b1; data(1'b0, 1'b0, 1'b1, 32'h1111_1111, 4'b0000); step();
        data(1'b1, 1'b0, 1'b0, 32'h2222_2223, 4'b0000);
        par = ~ep(32'h1111_1111, 4'b0000); step();
        idle_bus(); par = ep(32'h2222_2223, 4'b0000); step();
        chk("R8 wait clock not checked", par_err, 0);
        step(); step();
        chk("R8 line idle", perr_oe, 0);
    endtask

    // special cycle with bad parity
    task automatic t_special();
        do_reset();
        addr(32'h0000_0000, 4'b0001, 1'b0); step();
        tgt = 1'b1; data(1'b1, 1'b0, 1'b0, 32'h0000_0003, 4'b0000); step();
        idle_bus(); par = ~ep(32'h0000_0003, 4'b0000); step();
        chk("R7 special not checked", par_err, 0);
        step();
        chk("R7 line idle", perr_oe, 0);
    endtask

    // reporting disabled
    task automatic t_report_off();
        do_reset();
        perr_en = 1'b0;
        addr(32'h5000_0000, 4'b0111, 1'b0); step();
        tgt = 1'b1; data(1'b1, 1'b0, 1'b0, 32'h7777_0000, 4'b0000); step();
        idle_bus(); par = ~ep(32'h7777_0000, 4'b0000); step();
        chk("R9 status without enable", par_err, 1);
        step();
        chk("R9 line not driven", perr_oe, 0);
        step(); step();
        chk("R9 line still not driven", perr_oe, 0);
        perr_en = 1'b1;
    endtask

    // two bad words back to back extend the low time
    task automatic t_burst();
        do_reset();
        addr(32'h6000_0000, 4'b0111, 1'b0); step();
        tgt = 1'b1; data(1'b0, 1'b0, 1'b0, 32'hAAAA_0001, 4'b0000); step();
        data(1'b1, 1'b0, 1'b0, 32'hBBBB_0001, 4'b0000);
        par = ~ep(32'hAAAA_0001, 4'b0000); step();
        idle_bus(); par = ~ep(32'hBBBB_0001, 4'b0000); step();
        chk("R5 burst first low", perr_n, 0);
        step();
        chk("R6 burst second low", perr_n, 0);
        step();
        chk("R6 burst high 1", perr_n, 1);
        chk("R6 burst oe 1", perr_oe, 1);
        step();
        chk("R6 burst oe 2", perr_oe, 1);
        step();
        chk("R6 burst released", perr_oe, 0);
    endtask

    initial begin
        t_write_target_err();
        t_read_master();
        t_write_master();
        t_read_target();
        t_wait_ignored();
        t_special();
        t_report_off();
        t_burst();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule